// File: doc/BRIEF.md
# Angle-Modulated Function Generator

This block is the digital core of one output channel of a signal generator. A 32-bit phase accumulator advances by a frequency word every clock, and a phase word is added to its value. The resulting phase is turned into a sine, triangle or square sample. The shaping stage can also output a full-scale DC level, pass through a sample stream from an arbitrary-waveform source, or forward the output of the partner channel. A signed modulating sample, scaled by a deviation gain, can shift the frequency (FM) or the phase (PM) of the carrier. The same scaled sample can instead vary the gain or the offset of the final level stage.

The shape select, the angle-modulation mode and the level-modulation mode are independent fields that can change on any clock. The final stage multiplies the shaped sample by an amplitude word, adds an offset, and clips the result to the signed output range. The output is a signed sample bus that feeds a DAC. Generation keeps running while the output is muted, and a phase-clear strobe zeroes the accumulator.

Top module: `fgen_core`

## Requirements
- R1: Shape select code 0 drives a zero shaped sample. The accumulator keeps advancing while muted, so when a periodic shape is selected again its phase is the same as if the mute had never happened.
- R2: Shape code 1 gives 32767·sin(2π·P/2^32) within ±100 counts. P is the phase sum, and the sample comes from a quarter-wave table addressed by the top 12 bits of P.
- R3: Shape code 2 gives a triangle. Let T be P[31:16] and r = 2·T[14:0]. The sample is r−32768 when T[15]=0 and 32767−r when T[15]=1.
- R4: Shape code 4 gives +32767 when P[31]=0 and −32767 when P[31]=1.
- R5: Code 5 gives +32767 and code 6 passes the arbitrary sample input. Code 8 passes the partner input only when parameter IS_ODD=1 and gives zero otherwise. Every other code gives zero.
- R6: Each clock the accumulator A becomes A+F (plus any FM term). On the same clock the phase sum becomes P = A+Φ (plus any PM term), using the value A held before that edge. The shaped sample and the output are each one more register later.
- R7: When the phase-clear input is high at a clock edge, A becomes 0 and the frequency step is ignored for that edge.
- R8: Angle code 1 (FM) adds the low 32 bits of G·m to the step. G is the unsigned 16-bit deviation gain and m is the signed 16-bit modulating sample.
- R9: Angle code 2 (PM) adds the low 32 bits of G·m to P. With G=65535 and a full-scale m, the deviation is close to ±180 degrees.
- R10: Angle code 0 and the unused code 3 apply no modulation to the frequency or the phase.
- R11: With level code 0, out = floor(S·A/2^15) + O. Here S is the shaped sample, A is the unsigned amplitude word (32768 is unity gain) and O is the signed offset word.
- R12: Level code 1 replaces A with A + floor(G·m/2^15). Level code 2 replaces O with O + floor(G·m/2^15). Code 3 behaves like code 0.
- R13: A level-stage result above 32767 or below −32768 is clipped to that bound, never wrapped.
- R14: While reset is high, the accumulator, the phase sum, the shaped sample and the output are all held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_clr | input | 1 | Clears the phase accumulator |
| freq_word | input | 32 | Phase step per clock |
| phase_word | input | 32 | Carrier phase offset |
| wave_sel | input | 4 | Shape select code |
| ang_mode | input | 2 | Angle modulation mode: 0 off, 1 FM, 2 PM |
| lvl_mode | input | 2 | Level modulation mode: 0 off, 1 amplitude, 2 offset |
| dev_gain | input | 16 | Deviation gain (unsigned) |
| mod_in | input | 16 | Modulating sample (signed) |
| arb_in | input | 16 | Arbitrary-waveform sample (signed) |
| peer_in | input | 16 | Partner channel sample (signed) |
| amp_word | input | 16 | Amplitude, 32768 = unity |
| ofs_word | input | 16 | Offset (signed) |
| dout | output | 16 | Output sample (signed) |

## Verification
The bench goes after the level stage at both clipping rails by pushing a full-scale DC level past the top with a large offset, and a negative square half below the bottom. A design that wraps there would flip the sign of the sample. Phase-clear is pulsed while the frequency word is non-zero, which catches an accumulator that adds the step on the clearing edge and so shifts the carrier by one step. Mute periods sit between sine and triangle runs, so an accumulator that stalls while muted comes back at the wrong phase. The partner code is driven on an odd and an even instance side by side, and the unused angle and level codes 3 are applied, so that a missing default shows up as a stray modulation or a leaked input.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    typedef enum logic [3:0] {
        SEL_MUTE = 4'd0,
        SEL_SINE = 4'd1,
        SEL_TRI  = 4'd2,
        SEL_SQR  = 4'd4,
        SEL_DC   = 4'd5,
        SEL_ARB  = 4'd6,
        SEL_PEER = 4'd8
    } wave_sel_e;

    typedef enum logic [1:0] {
        ANG_NONE  = 2'd0,
        ANG_FREQ  = 2'd1,
        ANG_PHASE = 2'd2
    } ang_mode_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_AMP  = 2'd1,
        LVL_OFS  = 2'd2
    } lvl_mode_e;

    // Routing of the shared deviation product into the angle paths.
    typedef struct packed {
        logic fm_on;
        logic pm_on;
    } ang_route_t;

    // Quarter-wave table entry i, sampled at the centre of its bin.
    // A rational sine approximation keeps the fill free of real math.
    function automatic int sine_entry(int i, int aw, int peak);
        longint x;
        longint h;
        longint num;
        longint den;
        x   = 2 * longint'(i) + 1;
        h   = longint'(1) << (aw + 2);
        num = 16 * x * (h - x);
        den = 5 * h * h - 4 * x * (h - x);
        return int'((longint'(peak) * num + den / 2) / den);
    endfunction

    function automatic ang_route_t route_ang(ang_mode_e m);
        ang_route_t r;
        r.fm_on = (m == ANG_FREQ);
        r.pm_on = (m == ANG_PHASE);
        return r;
    endfunction

endpackage

// File: rtl/fgen_phase.sv
module fgen_phase #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phase_clr,
    input  logic [PH_W-1:0] freq_word,
    input  logic [PH_W-1:0] phase_word,
    input  logic [PH_W-1:0] fm_dev,
    input  logic [PH_W-1:0] pm_dev,
    output logic [PH_W-1:0] phase_q
);

    logic [PH_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || phase_clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + freq_word + fm_dev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= acc_q + phase_word + pm_dev;
        end
    end

    // R7: a clear strobe wins over accumulation
    assert_phase_clear_R7: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> (acc_q == '0));

    // R6: without clear or FM the accumulator advances by the frequency word
    assert_acc_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!phase_clr && fm_dev == '0) |=> (acc_q == $past(acc_q) + $past(freq_word)));

endmodule

// File: rtl/fgen_shape.sv
module fgen_shape
    import fgen_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int LUT_AW = 10,
    parameter bit IS_ODD = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SMP_W-1:0]        ph_top,
    input  logic [3:0]              wave_sel,
    input  logic signed [SMP_W-1:0] arb_in,
    input  logic signed [SMP_W-1:0] peer_in,
    output logic signed [SMP_W-1:0] wave_q
);

    localparam int LUT_N = 2 ** LUT_AW;
    localparam int PEAK  = 2 ** (SMP_W - 1) - 1;
    localparam logic signed [SMP_W-1:0] POS_FS = SMP_W'(PEAK);
    localparam logic signed [SMP_W-1:0] NEG_FS = -POS_FS;

    logic signed [SMP_W-1:0] lut [LUT_N];

    initial begin
        for (int i = 0; i < LUT_N; i++) begin
            lut[i] = SMP_W'(sine_entry(i, LUT_AW, PEAK));
        end
    end

    // quarter-wave folding: bit 0 of the quadrant mirrors, bit 1 negates
    logic [1:0]              quad;
    logic [LUT_AW-1:0]       idx;
    logic [LUT_AW-1:0]       addr;
    logic signed [SMP_W-1:0] lut_val;
    logic signed [SMP_W-1:0] sine_v;
    logic [SMP_W-1:0]        ramp;
    logic signed [SMP_W-1:0] tri_v;
    logic signed [SMP_W-1:0] sqr_v;
    logic signed [SMP_W-1:0] peer_v;
    logic signed [SMP_W-1:0] next_w;

    always_comb begin
        quad    = ph_top[SMP_W-1 -: 2];
        idx     = ph_top[SMP_W-3 -: LUT_AW];
        addr    = quad[0] ? ~idx : idx;
        lut_val = lut[addr];
        sine_v  = quad[1] ? -lut_val : lut_val;
        ramp    = {ph_top[SMP_W-2:0], 1'b0};
        tri_v   = ph_top[SMP_W-1] ? $signed({ramp[SMP_W-1], ~ramp[SMP_W-2:0]})
                                  : $signed({~ramp[SMP_W-1], ramp[SMP_W-2:0]});
        sqr_v   = ph_top[SMP_W-1] ? NEG_FS : POS_FS;
    end

    generate
        if (IS_ODD) begin : g_peer
            assign peer_v = peer_in;
        end else begin : g_no_peer
            assign peer_v = '0;
        end
    endgenerate

    always_comb begin
        case (wave_sel_e'(wave_sel))
            SEL_SINE: next_w = sine_v;
            SEL_TRI:  next_w = tri_v;
            SEL_SQR:  next_w = sqr_v;
            SEL_DC:   next_w = POS_FS;
            SEL_ARB:  next_w = arb_in;
            SEL_PEER: next_w = peer_v;
            default:  next_w = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= '0;
        end else begin
            wave_q <= next_w;
        end
    end

    // R1: mute gives a zero shaped sample on the next clock
    assert_mute_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (wave_sel == 4'd0) |=> (wave_q == '0));

    // R4: square keeps to the two full-scale levels
    assert_square_level_R4: assert property (@(posedge clk) disable iff (rst)
        (wave_sel == 4'd4) |=> (wave_q == POS_FS || wave_q == NEG_FS));

    generate
        if (!IS_ODD) begin : g_even_chk
            // R5: partner code is void on an even channel
            assert_peer_even_R5: assert property (@(posedge clk) disable iff (rst)
                (wave_sel == 4'd8) |=> (wave_q == '0));
        end
    endgenerate

endmodule

// File: rtl/fgen_level.sv
module fgen_level
    import fgen_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int LVL_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] wave_q,
    input  logic [SMP_W-1:0]        amp_word,
    input  logic signed [SMP_W-1:0] ofs_word,
    input  logic [1:0]              lvl_mode,
    input  logic signed [LVL_W-1:0] lvl_dev,
    output logic signed [SMP_W-1:0] dout
);

    localparam int AE_W  = LVL_W + 1;
    localparam int MUL_W = SMP_W + AE_W;
    localparam int SUM_W = AE_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(2 ** (SMP_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

    lvl_mode_e               mode;
    logic signed [AE_W-1:0]  amp_eff;
    logic signed [AE_W-1:0]  ofs_eff;
    logic signed [MUL_W-1:0] mult;
    logic signed [SUM_W-1:0] sum_c;
    logic signed [SMP_W-1:0] sat_c;

    always_comb begin
        mode    = lvl_mode_e'(lvl_mode);
        amp_eff = AE_W'($signed({1'b0, amp_word}))
                + ((mode == LVL_AMP) ? AE_W'(lvl_dev) : AE_W'(0));
        ofs_eff = AE_W'(ofs_word)
                + ((mode == LVL_OFS) ? AE_W'(lvl_dev) : AE_W'(0));
        mult    = wave_q * amp_eff;
        sum_c   = SUM_W'(mult >>> (SMP_W - 1)) + SUM_W'(ofs_eff);
        if (sum_c > SAT_HI) begin
            sat_c = SMP_W'(SAT_HI);
        end else if (sum_c < SAT_LO) begin
            sat_c = SMP_W'(SAT_LO);
        end else begin
            sat_c = SMP_W'(sum_c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout <= sat_c;
        end
    end

    // R13: overflow clips to the rails instead of wrapping
    assert_clip_high_R13: assert property (@(posedge clk) disable iff (rst)
        (sum_c > SAT_HI) |=> (dout == SMP_W'(SAT_HI)));

    assert_clip_low_R13: assert property (@(posedge clk) disable iff (rst)
        (sum_c < SAT_LO) |=> (dout == SMP_W'(SAT_LO)));

    // R11: with no offset, level stage keeps the sign of a positive gain
    assert_level_sign_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == LVL_NONE && ofs_word == '0 && wave_q > 0) |=> (dout >= 0));

endmodule

// File: rtl/fgen_core.sv
module fgen_core
    import fgen_pkg::*;
#(
    parameter int PH_W   = 32,
    parameter int SMP_W  = 16,
    parameter int GAIN_W = 16,
    parameter int LUT_AW = 10,
    parameter bit IS_ODD = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phase_clr,
    input  logic [PH_W-1:0]         freq_word,
    input  logic [PH_W-1:0]         phase_word,
    input  logic [3:0]              wave_sel,
    input  logic [1:0]              ang_mode,
    input  logic [1:0]              lvl_mode,
    input  logic [GAIN_W-1:0]       dev_gain,
    input  logic signed [SMP_W-1:0] mod_in,
    input  logic signed [SMP_W-1:0] arb_in,
    input  logic signed [SMP_W-1:0] peer_in,
    input  logic [SMP_W-1:0]        amp_word,
    input  logic signed [SMP_W-1:0] ofs_word,
    output logic signed [SMP_W-1:0] dout
);

    localparam int PROD_W = GAIN_W + SMP_W + 1;
    localparam int LVL_W  = PROD_W - (SMP_W - 1);

    // one deviation product shared by the FM, PM and level paths
    logic signed [PROD_W-1:0] dev_prod;
    logic [PH_W-1:0]          ph_dev;
    logic [PH_W-1:0]          fm_dev;
    logic [PH_W-1:0]          pm_dev;
    logic signed [LVL_W-1:0]  lvl_dev;
    ang_route_t               route;
    logic [PH_W-1:0]          phase_q;
    logic signed [SMP_W-1:0]  wave_q;

    always_comb begin
        dev_prod = $signed({1'b0, dev_gain}) * mod_in;
        ph_dev   = PH_W'(dev_prod);
        lvl_dev  = LVL_W'(dev_prod >>> (SMP_W - 1));
        route    = route_ang(ang_mode_e'(ang_mode));
        fm_dev   = route.fm_on ? ph_dev : '0;
        pm_dev   = route.pm_on ? ph_dev : '0;
    end

    fgen_phase #(
        .PH_W(PH_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase_clr (phase_clr),
        .freq_word (freq_word),
        .phase_word(phase_word),
        .fm_dev    (fm_dev),
        .pm_dev    (pm_dev),
        .phase_q   (phase_q)
    );

    fgen_shape #(
        .SMP_W (SMP_W),
        .LUT_AW(LUT_AW),
        .IS_ODD(IS_ODD)
    ) u_shape (
        .clk     (clk),
        .rst     (rst),
        .ph_top  (phase_q[PH_W-1 -: SMP_W]),
        .wave_sel(wave_sel),
        .arb_in  (arb_in),
        .peer_in (peer_in),
        .wave_q  (wave_q)
    );

    fgen_level #(
        .SMP_W(SMP_W),
        .LVL_W(LVL_W)
    ) u_level (
        .clk     (clk),
        .rst     (rst),
        .wave_q  (wave_q),
        .amp_word(amp_word),
        .ofs_word(ofs_word),
        .lvl_mode(lvl_mode),
        .lvl_dev (lvl_dev),
        .dout    (dout)
    );

    // R10: angle codes 0 and 3 leave both angle paths untouched
    assert_no_angle_R10: assert property (@(posedge clk) disable iff (rst)
        (ang_mode == 2'd0 || ang_mode == 2'd3) |-> (fm_dev == '0 && pm_dev == '0));

    // R8 R9: FM and PM are never both applied
    assert_one_angle_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({fm_dev != '0, pm_dev != '0}) <= 1);

endmodule

// File: tb/sim_fgen_core.sv
module sim_fgen_core;

    logic               clk = 1'b0;
    logic               rst;
    logic               phase_clr;
    logic [31:0]        freq, phs;
    logic [3:0]         sel;
    logic [1:0]         ang, lvl;
    logic [15:0]        gain, amp;
    logic signed [15:0] mod_s, ofs, arb, peer;
    logic signed [15:0] dout0, dout1;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string sect    = "R14 reset";

    always #4 clk = ~clk;   // 125 MHz

    fgen_core #(.IS_ODD(1'b1)) u0 (
        .clk(clk), .rst(rst), .phase_clr(phase_clr), .freq_word(freq), .phase_word(phs),
        .wave_sel(sel), .ang_mode(ang), .lvl_mode(lvl), .dev_gain(gain), .mod_in(mod_s),
        .arb_in(arb), .peer_in(peer), .amp_word(amp), .ofs_word(ofs), .dout(dout0));

    fgen_core #(.IS_ODD(1'b0)) u1 (
        .clk(clk), .rst(rst), .phase_clr(phase_clr), .freq_word(freq), .phase_word(phs),
        .wave_sel(sel), .ang_mode(ang), .lvl_mode(lvl), .dev_gain(gain), .mod_in(mod_s),
        .arb_in(arb), .peer_in(peer), .amp_word(amp), .ofs_word(ofs), .dout(dout1));

    // ---------------- reference model built from the requirements ----------------
    logic [31:0] m_acc, m_ph;
    int          m_wave [2];
    int          m_wtol [2];
    int          m_wtag [2];
    int          m_out  [2];
    int          m_otol [2];
    int          m_otag [2];
    longint      prod;
    logic [31:0] p32;

    function automatic int shape_fn(logic [31:0] p, int s, int a, int pr, bit odd,
                                    output int tol, output int tag);
        int t, r;
        tol = 0;
        case (s)
            0: begin tag = 1; return 0; end                      // R1
            1: begin                                             // R2
                tag = 2; tol = 100;
                return int'(32767.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 4294967296.0));
            end
            2: begin                                             // R3
                tag = 3; t = int'(p[31:16]); r = (t % 32768) * 2;
                return (t < 32768) ? r - 32768 : 32767 - r;
            end
            4: begin tag = 4; return p[31] ? -32767 : 32767; end // R4
            5: begin tag = 5; return 32767; end                  // R5
            6: begin tag = 5; return a; end
            8: begin tag = 5; return odd ? pr : 0; end
            default: begin tag = 5; return 0; end
        endcase
    endfunction

    function automatic int level_fn(int w, int wt, int a, int o, int md, longint pd,
                                    output int tol, output bit clip);
        longint l, ae, oe, s;
        l  = pd >>> 15;
        ae = longint'(a) + ((md == 1) ? l : 0);                  // R12
        oe = longint'(o) + ((md == 2) ? l : 0);
        s  = ((longint'(w) * ae) >>> 15) + oe;                   // R11
        tol = (wt == 0) ? 0 : int'((longint'(wt) * (ae < 0 ? -ae : ae)) / 32768) + 2;
        clip = 1'b0;
        if (s > 32767)  begin s = 32767;  clip = 1'b1; end       // R13
        if (s < -32768) begin s = -32768; clip = 1'b1; end
        return int'(s);
    endfunction

    always @(posedge clk) begin
        if (rst) begin                                           // R14
            m_acc = '0; m_ph = '0;
            for (int c = 0; c < 2; c++) begin
                m_wave[c] = 0; m_wtol[c] = 0; m_wtag[c] = 14;
                m_out[c] = 0;  m_otol[c] = 0; m_otag[c] = 14;
            end
        end else begin
            prod = longint'(gain) * longint'(mod_s);
            p32  = prod[31:0];
            for (int c = 0; c < 2; c++) begin
                bit clip;
                int ot;
                m_out[c]  = level_fn(m_wave[c], m_wtol[c], int'(amp), int'(ofs), int'(lvl), prod, ot, clip);
                m_otol[c] = ot;
                m_otag[c] = clip ? 13 : ((lvl == 2'd1 || lvl == 2'd2) ? 12 : m_wtag[c]);
            end
            for (int c = 0; c < 2; c++) begin
                int wt, tg;
                m_wave[c] = shape_fn(m_ph, int'(sel), int'(arb), int'(peer), (c == 0), wt, tg);
                m_wtol[c] = wt;
                m_wtag[c] = tg;
            end
            m_ph  = m_acc + phs + ((ang == 2'd2) ? p32 : 32'd0);           // R6 R9
            m_acc = phase_clr ? 32'd0 : m_acc + freq + ((ang == 2'd1) ? p32 : 32'd0); // R7 R8
        end
    end

    // ---------------- checking ----------------
    task automatic chk();
        for (int c = 0; c < 2; c++) begin
            int got, diff;
            got  = (c == 0) ? int'(dout0) : int'(dout1);
            diff = got - m_out[c];
            if (diff < 0) diff = -diff;
            n_tests++;
            if (diff > m_otol[c]) begin
                n_fail++;
                $display("FAIL R%0d [%s] ch%0d got %0d expected %0d (tol %0d)",
                         m_otag[c], sect, c, got, m_out[c], m_otol[c]);
            end
        end
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            chk();
            mod_s = 16'($urandom);
            arb   = 16'($urandom);
            peer  = 16'($urandom);
        end
    endtask

    task automatic direct(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; phase_clr = 1'b0; freq = '0; phs = '0; sel = 4'd0;
        ang = 2'd0; lvl = 2'd0; gain = '0; amp = 16'd32768; ofs = '0;
        mod_s = '0; arb = '0; peer = '0;
        repeat (3) @(negedge clk);
        // R14: reset state, with live stimulus applied
        sel = 4'd5; freq = 32'h1000_0000;
        @(negedge clk);
        direct("R14 reset ch0", int'(dout0), 0);
        direct("R14 reset ch1", int'(dout1), 0);
        chk();
        rst = 1'b0;

        sect = "R4 square R6 accumulator"; sel = 4'd4; freq = 32'h1000_0000;
        run(40);
        sect = "R3 triangle"; sel = 4'd2; freq = 32'h0123_4567; phs = 32'h4000_0000;
        run(40);
        sect = "R2 sine"; sel = 4'd1; freq = $urandom; phs = $urandom;
        run(60);
        sect = "R1 mute keeps phase"; sel = 4'd0;
        run(9);
        sel = 4'd2; run(12);
        sect = "R7 phase clear";
        phase_clr = 1'b1; run(1); phase_clr = 1'b0; run(6);
        phase_clr = 1'b1; run(3); phase_clr = 1'b0; run(10);
        sect = "R8 FM"; ang = 2'd1; gain = 16'd3000; sel = 4'd2;
        run(50);
        sect = "R9 PM"; ang = 2'd2; gain = 16'd65535; sel = 4'd4; freq = 32'h0200_0000;
        run(40);
        sel = 4'd1; run(30);
        sect = "R10 angle code 3"; ang = 2'd3; sel = 4'd2;
        run(30);
        ang = 2'd0;
        sect = "R5 dc arb peer";
        sel = 4'd5; run(8);
        sel = 4'd6; run(10);
        sel = 4'd8; run(10);
        sel = 4'd3; run(6);
        sel = 4'd7; run(6);
        sel = 4'd15; run(6);
        sect = "R11 level"; sel = 4'd2; amp = 16'd20000; ofs = -16'sd3000; lvl = 2'd0;
        run(30);
        sect = "R12 amplitude mod"; gain = 16'd9000; lvl = 2'd1; amp = 16'd16384; ofs = '0;
        run(30);
        sect = "R12 offset mod"; lvl = 2'd2; run(30);
        sect = "R12 level code 3"; lvl = 2'd3; run(20);
        lvl = 2'd0;
        sect = "R13 clip high"; sel = 4'd5; amp = 16'd65535; ofs = 16'sd30000;
        run(10);
        direct("R13 clip high ch0", int'(dout0), 32767);
        sect = "R13 clip low"; sel = 4'd4; ofs = -16'sd32768; freq = 32'h1000_0000;
        run(40);

        sect = "random mix";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(15) == 0) begin
                case ($urandom_range(8))
                    0: sel = 4'd0; 1: sel = 4'd1; 2: sel = 4'd2; 3: sel = 4'd4;
                    4: sel = 4'd5; 5: sel = 4'd6; 6: sel = 4'd8; 7: sel = 4'd3;
                    default: sel = 4'd7;
                endcase
            end
            if ($urandom_range(15) == 0) ang  = 2'($urandom);
            if ($urandom_range(15) == 0) lvl  = 2'($urandom);
            if ($urandom_range(15) == 0) gain = 16'($urandom);
            if ($urandom_range(15) == 0) amp  = 16'($urandom);
            if ($urandom_range(15) == 0) ofs  = 16'($urandom);
            if ($urandom_range(31) == 0) freq = $urandom;
            if ($urandom_range(31) == 0) phs  = $urandom;
            phase_clr = ($urandom_range(31) == 0);
            run(1);
        end
        phase_clr = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired in section %s", sect);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule